// File: doc/BRIEF.md
# Page Write Collector and Commit Sequencer

This block sits behind a two-wire serial memory front end. Once the front end has decoded a write command and its two address bytes, it hands over the 12-bit memory address. Each data byte that follows is placed in a 32-byte page latch. The upper seven address bits pick the page and stay fixed for the whole transaction. Only the five-bit byte offset moves. When the offset passes the last byte of a page, it wraps to the first byte of the same page, so later bytes replace ones latched earlier.

A stop strobe ends data input. If at least one byte was latched, the block starts a timed write cycle. It scans the page slots in ascending order and drives the array write port for each slot that received a byte. It holds a busy flag for a programmable number of clock cycles, counted from the stop. While busy, it ignores new address, byte and stop strobes. When the cycle ends, it pulses a valid strobe with the address that follows the last byte written, wrapped within the page, so the front end can update its current-address counter.

With the write-protect level high, bytes are refused. A transaction whose bytes were all refused, or one with no data at all (such as the dummy write before a random read), starts no write cycle.

Top module: `page_wbuf`

## Requirements
- R1: After reset, busy, the array write enable and the next-address valid strobe are all low.
- R2: An address strobe while not busy starts a new transaction. It loads the page (bits 11..5) and the offset (bits 4..0), and it marks every page slot as empty.
- R3: A byte strobe while not busy, with write protect low, and not in the same cycle as an address strobe, stores the byte at the current offset. The offset then advances by one modulo 32, and the page bits do not change.
- R4: After offset 31 the next accepted byte goes to offset 0 of the same page and replaces any byte latched there earlier in the transaction.
- R5: A stop strobe while not busy, with at least one byte latched, raises busy on the next cycle. Busy stays high for exactly WC_CYCLES cycles.
- R6: During the first 32 busy cycles, busy cycle k (counted from 0) drives one array write for slot k if that slot holds a byte. The write address is {page, k} and the data is the last byte stored there. No other array writes occur.
- R7: A byte strobe with write protect high is not stored and does not advance the offset.
- R8: A stop strobe with no byte latched leaves busy low and produces no array write.
- R9: Address, byte and stop strobes that arrive while busy is high have no effect.
- R10: In the cycle busy falls, the next-address valid strobe is high for one cycle. The next address is {page, (start offset + number of accepted bytes) mod 32}.
- R11: A completed write cycle empties the page latch. A later stop with no new bytes starts no write cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_vld_i | input | 1 | Start-address strobe (begins a write transaction) |
| addr_i | input | ADDR_W | Start address of the transaction |
| byte_vld_i | input | 1 | Data byte strobe |
| byte_i | input | DATA_W | Data byte |
| stop_i | input | 1 | Stop strobe from the bus front end |
| wp_i | input | 1 | Write-protect level, high refuses data bytes |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | DATA_W | Array write data |
| busy_o | output | 1 | Write cycle in progress |
| next_addr_vld_o | output | 1 | One-cycle strobe marking next_addr_o as new |
| next_addr_o | output | ADDR_W | Address following the last written byte |

## Verification
On every cycle, the bound checker confirms the following: busy rises only after a stop, and busy lasts exactly the programmed length. Array writes occur only inside the first 32 busy cycles, and the page bits of the write address stay steady while busy. The completion strobe coincides with the fall of busy. Only the bench scenarios can show the rest: that the right bytes land in the right slots, that wrap-around overwrite happens, that protected or mid-cycle bytes are dropped, and that empty stops do nothing. To do so, the bench sweeps every start offset with byte counts up to 40, so the wrap is exercised, and compares each array write and each reported address with values it computes itself.

// File: rtl/page_wbuf_pkg.sv
package page_wbuf_pkg;
   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_COMMIT = 2'd1,
      PH_HOLD   = 2'd2
   } wb_phase_e;
endpackage

// File: rtl/page_wbuf_ptr.sv
// Page/offset pointer: page bits fixed per transaction, offset wraps in page.
module page_wbuf_ptr #(
   parameter int ADDR_W = 12,
   parameter int OFF_W  = 5,
   localparam int PG_W  = ADDR_W - OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              step,
   output logic [PG_W-1:0]   page,
   output logic [OFF_W-1:0]  off
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page <= '0;
         off  <= '0;
      end else if (load) begin
         page <= load_addr[ADDR_W-1:OFF_W];
         off  <= load_addr[OFF_W-1:0];
      end else if (step) begin
         off  <= off + 1'b1;
      end
   end
endmodule

// File: rtl/page_wbuf_latch.sv
// Page latch: one data register and one valid bit per slot.
module page_wbuf_latch #(
   parameter int DATA_W     = 8,
   parameter int PAGE_BYTES = 32,
   localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_en,
   input  logic [OFF_W-1:0]  wr_off,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [OFF_W-1:0]  rd_off,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_vld,
   output logic              any_vld
);
   logic [PAGE_BYTES-1:0] vld_vec;
   logic [DATA_W-1:0]     slot_dat [PAGE_BYTES];

   for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
      logic              vld_q;
      logic [DATA_W-1:0] dat_q;
      logic              hit;
      assign hit = wr_en && (wr_off == OFF_W'(s));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
            dat_q <= '0;
         end else if (clr) begin
            vld_q <= 1'b0;
         end else if (hit) begin
            vld_q <= 1'b1;
            dat_q <= wr_data;
         end
      end
      assign vld_vec[s]  = vld_q;
      assign slot_dat[s] = dat_q;
   end

   assign rd_data = slot_dat[rd_off];
   assign rd_vld  = vld_vec[rd_off];
   assign any_vld = |vld_vec;
endmodule

// File: rtl/page_wbuf_timer.sv
// Write-cycle sequencer: scan phase over the slots, then hold until the length ends.
module page_wbuf_timer
   import page_wbuf_pkg::*;
#(
   parameter int WC_CYCLES  = 64,
   parameter int PAGE_BYTES = 32,
   localparam int OFF_W     = $clog2(PAGE_BYTES),
   localparam int CNT_W     = $clog2(WC_CYCLES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   output wb_phase_e        phase,
   output logic [OFF_W-1:0] scan_off,
   output logic             done
);
   logic [CNT_W-1:0] cnt;
   logic             last;

   assign last     = (cnt == CNT_W'(WC_CYCLES - 1));
   assign scan_off = cnt[OFF_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (phase)
            PH_IDLE: begin
               if (go) begin
                  phase <= PH_COMMIT;
                  cnt   <= '0;
               end
            end
            PH_COMMIT: begin
               if (last) begin
                  phase <= PH_IDLE;
                  done  <= 1'b1;
               end else begin
                  if (cnt == CNT_W'(PAGE_BYTES - 1)) phase <= PH_HOLD;
                  cnt <= cnt + 1'b1;
               end
            end
            PH_HOLD: begin
               if (last) begin
                  phase <= PH_IDLE;
                  done  <= 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/page_wbuf.sv
// Page write collector and commit sequencer (top).
module page_wbuf
   import page_wbuf_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int DATA_W     = 8,
   parameter int PAGE_BYTES = 32,
   parameter int WC_CYCLES  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_vld_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              byte_vld_i,
   input  logic [DATA_W-1:0] byte_i,
   input  logic              stop_i,
   input  logic              wp_i,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   output logic              busy_o,
   output logic              next_addr_vld_o,
   output logic [ADDR_W-1:0] next_addr_o
);
   localparam int OFF_W = $clog2(PAGE_BYTES);
   localparam int PG_W  = ADDR_W - OFF_W;

   initial begin
      assert (PAGE_BYTES >= 2 && (1 << OFF_W) == PAGE_BYTES)
         else $error("PAGE_BYTES must be a power of two");
      assert (ADDR_W > OFF_W) else $error("ADDR_W must exceed offset width");
      assert (WC_CYCLES >= PAGE_BYTES) else $error("WC_CYCLES shorter than scan");
   end

   wb_phase_e          phase;
   logic [OFF_W-1:0]   scan_off;
   logic               done;
   logic [PG_W-1:0]    page;
   logic [OFF_W-1:0]   off;
   logic               load, accept, go, any_vld, rd_vld;
   logic [DATA_W-1:0]  rd_data;

   assign busy_o = (phase != PH_IDLE);
   assign load   = addr_vld_i && !busy_o;
   assign accept = byte_vld_i && !busy_o && !wp_i && !load;
   assign go     = stop_i && !busy_o && any_vld;

   page_wbuf_ptr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .load(load), .load_addr(addr_i),
      .step(accept), .page(page), .off(off)
   );

   page_wbuf_latch #(.DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) u_latch (
      .clk(clk), .rst_n(rst_n), .clr(load || done), .wr_en(accept),
      .wr_off(off), .wr_data(byte_i), .rd_off(scan_off),
      .rd_data(rd_data), .rd_vld(rd_vld), .any_vld(any_vld)
   );

   page_wbuf_timer #(.WC_CYCLES(WC_CYCLES), .PAGE_BYTES(PAGE_BYTES)) u_timer (
      .clk(clk), .rst_n(rst_n), .go(go), .phase(phase),
      .scan_off(scan_off), .done(done)
   );

   assign mem_we_o        = (phase == PH_COMMIT) && rd_vld;
   assign mem_addr_o      = {page, scan_off};
   assign mem_wdata_o     = rd_data;
   assign next_addr_vld_o = done;
   assign next_addr_o     = {page, off};
endmodule

// File: rtl/page_wbuf_chk.sv
module page_wbuf_chk #(
   parameter int ADDR_W     = 12,
   parameter int DATA_W     = 8,
   parameter int PAGE_BYTES = 32,
   parameter int WC_CYCLES  = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              stop_i,
   input logic              mem_we_o,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic [DATA_W-1:0] mem_wdata_o,
   input logic              busy_o,
   input logic              next_addr_vld_o
);
   localparam int OFF_W = $clog2(PAGE_BYTES);
   localparam int CNT_W = $clog2(WC_CYCLES + 1);

   logic [CNT_W-1:0] bcnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bcnt <= '0;
      else if (busy_o) bcnt <= bcnt + 1'b1;
      else             bcnt <= '0;
   end

   a_r6_we_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> busy_o);
   a_r6_we_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> (bcnt < CNT_W'(PAGE_BYTES)));
   a_r6_page_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(mem_addr_o[ADDR_W-1:OFF_W]));
   a_r5_rise_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(stop_i));
   a_r5_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && $past(busy_o)) |-> (bcnt == CNT_W'(WC_CYCLES)));
   a_r5_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (bcnt < CNT_W'(WC_CYCLES)));
   a_r10_done_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
      next_addr_vld_o |-> (!busy_o && $past(busy_o)));
endmodule

bind page_wbuf page_wbuf_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES), .WC_CYCLES(WC_CYCLES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .mem_we_o(mem_we_o),
   .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .busy_o(busy_o),
   .next_addr_vld_o(next_addr_vld_o)
);

// File: tb/test_page_wbuf.sv
`timescale 1ns/1ps
module test_page_wbuf;
   localparam int AW = 12;
   localparam int DW = 8;
   localparam int PB = 32;
   localparam int WC = 40;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          addr_vld = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          byte_vld = 1'b0;
   logic [DW-1:0] bdat = '0;
   logic          stop = 1'b0;
   logic          wp = 1'b0;
   logic          mem_we, busy, nvld;
   logic [AW-1:0] mem_addr, naddr;
   logic [DW-1:0] mem_wdata;

   always #5 clk = ~clk;

   page_wbuf #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PB), .WC_CYCLES(WC)) i_page_wbuf (
      .clk(clk), .rst_n(rst_n), .addr_vld_i(addr_vld), .addr_i(addr),
      .byte_vld_i(byte_vld), .byte_i(bdat), .stop_i(stop), .wp_i(wp),
      .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
      .busy_o(busy), .next_addr_vld_o(nvld), .next_addr_o(naddr)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   // bench model
   logic [6:0]    m_page;
   logic [4:0]    m_off;
   logic [DW-1:0] m_dat [PB];
   bit            m_vld [PB];
   int            m_cnt;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic do_load(input logic [AW-1:0] a);
      @(negedge clk); addr_vld = 1'b1; addr = a;
      @(negedge clk); addr_vld = 1'b0;
      m_page = a[11:5]; m_off = a[4:0]; m_cnt = 0;
      for (int s = 0; s < PB; s++) m_vld[s] = 1'b0;
   endtask

   task automatic do_byte(input logic [DW-1:0] d, input bit prot);
      @(negedge clk); byte_vld = 1'b1; bdat = d; wp = prot;
      @(negedge clk); byte_vld = 1'b0; wp = 1'b0;
      if (!prot) begin
         m_dat[m_off] = d; m_vld[m_off] = 1'b1; m_off = m_off + 1'b1; m_cnt++;
      end
   endtask

   // stop, then follow the whole write cycle (or its absence)
   task automatic do_stop(input bit poke);
      @(negedge clk); stop = 1'b1;
      @(negedge clk); stop = 1'b0;
      if (m_cnt == 0) begin
         // R8 / R11: empty stop starts nothing
         for (int i = 0; i < 4; i++) begin
            chk(!busy && !mem_we, "R8 empty stop", {busy, mem_we}, 0);
            @(negedge clk);
         end
      end else begin
         for (int i = 0; i < WC; i++) begin
            bit exp_we;
            exp_we = (i < PB) && m_vld[i];
            chk(busy == 1'b1, "R5 busy held", busy, 1);
            chk(mem_we == exp_we, "R6 write enable", mem_we, exp_we);
            if (mem_we && exp_we) begin
               chk(mem_addr == {m_page, 5'(i)}, "R6 write address", mem_addr, {m_page, 5'(i)});
               chk(mem_wdata == m_dat[i], "R4 R6 write data", mem_wdata, m_dat[i]);
            end
            if (poke && i == 3) begin
               // R9: strobes during busy have no effect
               addr_vld = 1'b1; addr = 12'hFFF; byte_vld = 1'b1; bdat = 8'h5A; stop = 1'b1;
            end else begin
               addr_vld = 1'b0; byte_vld = 1'b0; stop = 1'b0;
            end
            @(negedge clk);
         end
         chk(!busy, "R5 busy ends", busy, 0);
         chk(nvld, "R10 completion strobe", nvld, 1);
         chk(naddr == {m_page, m_off}, "R9 R10 next address", naddr, {m_page, m_off});
         @(negedge clk);
         chk(!nvld, "R10 strobe one cycle", nvld, 0);
         for (int s = 0; s < PB; s++) m_vld[s] = 1'b0;
         m_cnt = 0;
      end
   endtask

   initial begin
      #2;
      chk(!busy && !mem_we && !nvld, "R1 in reset", {busy, mem_we, nvld}, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !mem_we && !nvld, "R1 after reset", {busy, mem_we, nvld}, 0);

      // R2 R3 R4 R7: sweep every start offset, byte counts up to 40
      for (int t = 0; t < 32; t++) begin
         int n;
         logic [6:0] pg;
         n  = (t * 7) % 40 + 1;
         pg = 7'((t * 5 + 3) % 128);
         do_load({pg, 5'(t)});
         for (int k = 0; k < n; k++)
            do_byte(8'((t * 37 + k * 11) & 255), (t % 4 == 3) && (k % 3 == 1));
         do_stop(t % 5 == 2);
         if (t % 5 == 2) do_stop(1'b0);   // R11: latch emptied, poked byte ignored
      end

      // R8: dummy write (address only, then stop)
      do_load(12'h4A7);
      do_stop(1'b0);

      // R7: all bytes protected -> no cycle
      do_load(12'h123);
      for (int k = 0; k < 5; k++) do_byte(8'(k + 1), 1'b1);
      do_stop(1'b0);

      // R4: exactly 33 bytes from offset 0 overwrite slot 0
      do_load(12'hA00);
      for (int k = 0; k < 33; k++) do_byte(8'(k + 100), 1'b0);
      chk(m_dat[0] == 8'd132, "R4 model wrap", m_dat[0], 132);
      do_stop(1'b0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule